// File: doc/BRIEF.md
# Serial Five-Bit Configuration Port

This block sits on a CPU write bus and builds configuration words one bit at a time. Each accepted write either restarts the serial sequence or contributes its data bit 0. After five contributing writes, the collected word is stored in one of three five-bit registers. The upper address bits of that fifth write pick the register: control, register A or register B. One address code discards the word.

Register B bit 4 drives a flag that disables the work-RAM window. Register A bit 4 serves two purposes. It controls a companion timer, which is told when to clear its counter and when to drop its pending interrupt. It also arms a sticky unlock flag for the program memory. That flag is set only after bit 4 has been stored low and is then stored high again. The translation logic reads the three registers and the two flags; the timer reads the two event pulses.

Top module: `serial_cfg_port`

## Requirements
- R1: A write is accepted only when `wr_en` is high and `addr_hi[2]` (CPU address bit 15) is high. Any other write leaves all registers, flags and the serial sequence unchanged.
- R2: An accepted write with data bit 7 set does three things. It empties the shift state, sets control bits 3:2 (an OR with 0x0C), and loads no register.
- R3: An accepted write with data bit 7 clear shifts in data bit 0. The first such write supplies the least significant bit, and data bits 6:1 are ignored. The fifth such write commits the five bits and restarts the count at zero.
- R4: The committing write's `addr_hi[1:0]` (address bits 14:13) selects the destination: 0 for control, 1 for register A, 2 for no register (the word is dropped), and 3 for register B.
- R5: After synchronous reset, control is 0x0C, register A is 0x10, register B is 0, and `wram_off`, `prg_unlocked` and both timer pulses are 0.
- R6: Every load of register B copies its bit 4 into `wram_off`. A value of 1 means the window is disabled.
- R7: A load of register A with bit 4 clear sets an internal seen-low flag, which stays set until reset. A load that moves bit 4 from 0 to 1 while seen-low is set raises `prg_unlocked`, which then stays high until reset.
- R8: `tmr_pend_clr` is a one-cycle pulse. It is high in the cycle after a register A load that changes bit 4 in either direction.
- R9: `tmr_cnt_clr` is a one-cycle pulse. It is high in the cycle after any register A load whose new bit 4 is 1.
- R10: A register, flag or pulse changed by a write shows its new value in the cycle after the clock edge that accepts that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe |
| addr_hi | input | 3 | CPU address bits 15:13 |
| wr_data | input | 8 | CPU write data |
| ctrl_q | output | 5 | Control register |
| rega_q | output | 5 | Register A |
| regb_q | output | 5 | Register B |
| wram_off | output | 1 | Work-RAM window disable |
| prg_unlocked | output | 1 | Sticky program unlock flag |
| tmr_pend_clr | output | 1 | Pulse: timer drops its pending interrupt |
| tmr_cnt_clr | output | 1 | Pulse: timer clears its counter |

## Verification
If the bit counter is out of step, the next word goes to the right register but rotated or truncated. The error shows on a register output one cycle after the fifth write. If the shift state is not cleared by a restart write, it corrupts the word that follows, which is visible as soon as that word lands. A wrong seen-low or old-bit-4 state can unlock early, fail to unlock, or pulse the timer at the wrong moment. Since `prg_unlocked` is sticky, a wrong unlock cannot heal and shows for the rest of the run.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int REG_W    = 5;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 2;
  localparam int NUM_DEST = 1 << SEL_W;
  localparam int GATE_BIT = 4;

  typedef enum logic [SEL_W-1:0] {
    DST_CTRL = 2'd0,
    DST_A    = 2'd1,
    DST_NONE = 2'd2,
    DST_B    = 2'd3
  } dest_e;

  localparam logic [REG_W-1:0] MODE_FORCE = 5'h0C;
  localparam logic [REG_W-1:0] CTRL_RST   = MODE_FORCE;
  localparam logic [REG_W-1:0] REGA_RST   = 5'h10;
  localparam logic [REG_W-1:0] REGB_RST   = 5'h00;

  // Restart write: mode bits forced on, other bits kept.
  function automatic logic [REG_W-1:0] force_mode(input logic [REG_W-1:0] c);
    return c | MODE_FORCE;
  endfunction

  // Place a serial bit at the position given by the running count.
  function automatic logic [REG_W-1:0] place_bit(input logic b, input int unsigned pos);
    logic [REG_W-1:0] one;
    one = '0;
    one[0] = b;
    return one << pos;
  endfunction

endpackage

// File: rtl/cfgport_shifter.sv
module cfgport_shifter
  import cfgport_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic [DW-1:0] din,
  output logic          clr_wr,
  output logic          commit,
  output logic [RW-1:0] commit_val
);
  localparam int CNT_W = $clog2(RW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RW - 1);

  logic [RW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             shift_wr;
  logic [RW-1:0]    sh_next;

  assign clr_wr     = acc & din[DW-1];
  assign shift_wr   = acc & ~din[DW-1];
  assign sh_next    = sh_q | place_bit(din[0], 32'(cnt_q));
  assign commit     = shift_wr && (cnt_q == LAST);
  assign commit_val = sh_next;

  always_ff @(posedge clk) begin
    if (rst || clr_wr || commit) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_wr) begin
      sh_q  <= sh_next;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int SW      = SEL_W,
  parameter int DISCARD = int'(DST_NONE)
) (
  input  logic             commit,
  input  logic [SW-1:0]    sel,
  output logic [(1<<SW)-1:0] ld
);
  localparam int ND = 1 << SW;

  for (genvar i = 0; i < ND; i++) begin : g_dest
    if (i == DISCARD) begin : g_drop
      assign ld[i] = 1'b0;
    end else begin : g_keep
      assign ld[i] = commit && (sel == SW'(i));
    end
  end
endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
#(
  parameter logic RST_BIT = REGA_RST[GATE_BIT]
) (
  input  logic clk,
  input  logic rst,
  input  logic ld_a,
  input  logic new_bit,
  input  logic old_bit,
  output logic a_rise,
  output logic a_fall,
  output logic seen_low,
  output logic unlocked,
  output logic pend_clr,
  output logic cnt_clr
);
  logic seen_low_q, unlocked_q;

  assign a_rise   = ld_a && !old_bit && new_bit;
  assign a_fall   = ld_a && old_bit && !new_bit;
  assign seen_low = seen_low_q;
  assign unlocked = unlocked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_low_q <= 1'b0;
      unlocked_q <= 1'b0;
      pend_clr   <= 1'b0;
      cnt_clr    <= 1'b0;
    end else begin
      if (ld_a && !new_bit) seen_low_q <= 1'b1;
      if (a_rise && seen_low_q) unlocked_q <= 1'b1;
      pend_clr <= a_rise | a_fall;
      cnt_clr  <= ld_a & new_bit;
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgport_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW:0]   addr_hi,
  input  logic [DW-1:0] wr_data,
  output logic [RW-1:0] ctrl_q,
  output logic [RW-1:0] rega_q,
  output logic [RW-1:0] regb_q,
  output logic          wram_off,
  output logic          prg_unlocked,
  output logic          tmr_pend_clr,
  output logic          tmr_cnt_clr
);
  localparam int ND = 1 << SW;

  logic          acc;
  logic          clr_wr;
  logic          commit;
  logic [RW-1:0] commit_val;
  logic [ND-1:0] ld;
  logic          a_rise, a_fall, seen_low;

  assign acc = wr_en & addr_hi[SW];

  cfgport_shifter #(.RW(RW), .DW(DW)) u_shift (
    .clk(clk), .rst(rst), .acc(acc), .din(wr_data),
    .clr_wr(clr_wr), .commit(commit), .commit_val(commit_val)
  );

  cfgport_decode #(.SW(SW), .DISCARD(int'(DST_NONE))) u_dec (
    .commit(commit), .sel(addr_hi[SW-1:0]), .ld(ld)
  );

  cfgport_unlock #(.RST_BIT(REGA_RST[GATE_BIT])) u_unl (
    .clk(clk), .rst(rst), .ld_a(ld[DST_A]),
    .new_bit(commit_val[GATE_BIT]), .old_bit(rega_q[GATE_BIT]),
    .a_rise(a_rise), .a_fall(a_fall), .seen_low(seen_low),
    .unlocked(prg_unlocked), .pend_clr(tmr_pend_clr), .cnt_clr(tmr_cnt_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      rega_q   <= REGA_RST;
      regb_q   <= REGB_RST;
      wram_off <= REGB_RST[GATE_BIT];
    end else begin
      if (ld[DST_CTRL])  ctrl_q <= commit_val;
      else if (clr_wr)   ctrl_q <= force_mode(ctrl_q);
      if (ld[DST_A])     rega_q <= commit_val;
      if (ld[DST_B]) begin
        regb_q   <= commit_val;
        wram_off <= commit_val[GATE_BIT];
      end
    end
  end
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr_wr,
  input logic       commit,
  input logic [1:0] sel,
  input logic [4:0] ctrl_q,
  input logic [4:0] rega_q,
  input logic [4:0] regb_q,
  input logic       wram_off,
  input logic       prg_unlocked,
  input logic       seen_low,
  input logic       tmr_pend_clr,
  input logic       tmr_cnt_clr
);
  p_force_mode_r2: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ctrl_q[3:2] == 2'b11);

  p_no_load_on_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> $stable(rega_q) && $stable(regb_q));

  p_discard_r4: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == 2'd2) |=> $stable(ctrl_q) && $stable(rega_q) && $stable(regb_q));

  p_wram_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    (regb_q != $past(regb_q)) |-> wram_off == regb_q[4]);

  p_unlock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    prg_unlocked |=> prg_unlocked);

  p_unlock_needs_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(prg_unlocked) |-> rega_q[4] && !$past(rega_q[4]) && $past(seen_low));

  p_pend_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (rega_q[4] != $past(rega_q[4])) |-> tmr_pend_clr);

  p_cnt_needs_bit_r9: assert property (@(posedge clk) disable iff (rst)
    tmr_cnt_clr |-> rega_q[4]);
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
  .clk(clk), .rst(rst), .clr_wr(clr_wr), .commit(commit), .sel(addr_hi[1:0]),
  .ctrl_q(ctrl_q), .rega_q(rega_q), .regb_q(regb_q), .wram_off(wram_off),
  .prg_unlocked(prg_unlocked), .seen_low(seen_low),
  .tmr_pend_clr(tmr_pend_clr), .tmr_cnt_clr(tmr_cnt_clr)
);

// File: tb/tb_serial_cfg_port.sv
`timescale 1ns/1ps
module tb_serial_cfg_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr_hi = 3'b000;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] ctrl_q, rega_q, regb_q;
  logic       wram_off, prg_unlocked, tmr_pend_clr, tmr_cnt_clr;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] prev_a;

  always #2.5 clk = ~clk;

  serial_cfg_port dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr_hi(addr_hi), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .rega_q(rega_q), .regb_q(regb_q), .wram_off(wram_off),
    .prg_unlocked(prg_unlocked), .tmr_pend_clr(tmr_pend_clr), .tmr_cnt_clr(tmr_cnt_clr)
  );

  // {dest[1:0], value[4:0], exp_ctrl, exp_rega, exp_regb, exp_unlock}
  localparam logic [22:0] VEC [8] = '{
    {2'd0, 5'h13, 5'h13, 5'h10, 5'h00, 1'b0},
    {2'd3, 5'h1A, 5'h13, 5'h10, 5'h1A, 1'b0},
    {2'd2, 5'h07, 5'h13, 5'h10, 5'h1A, 1'b0},
    {2'd1, 5'h05, 5'h13, 5'h05, 5'h1A, 1'b0},
    {2'd3, 5'h03, 5'h13, 5'h05, 5'h03, 1'b0},
    {2'd1, 5'h1C, 5'h13, 5'h1C, 5'h03, 1'b1},
    {2'd0, 5'h00, 5'h00, 5'h1C, 5'h03, 1'b1},
    {2'd1, 5'h1C, 5'h00, 5'h1C, 5'h03, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One bus write; returns at the falling edge after the accepting edge.
  task automatic wr(input logic en, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = en; addr_hi = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Five serial writes, bits 6:1 filled with noise (R3).
  task automatic ser(input logic [1:0] dest, input logic [4:0] v);
    for (int k = 0; k < 5; k++)
      wr(1'b1, {1'b1, dest}, {1'b0, 6'h2A ^ 6'(k), v[k]});
  endtask

  task automatic chk_a_pulses(input logic [4:0] oldv, input logic [4:0] newv);
    chk("R8 pend_clr", 8'(tmr_pend_clr), 8'(oldv[4] != newv[4]));
    chk("R9 cnt_clr", 8'(tmr_cnt_clr), 8'(newv[4]));
  endtask

  task automatic chk_reset_state();
    chk("R5 ctrl", 8'(ctrl_q), 8'h0C);
    chk("R5 rega", 8'(rega_q), 8'h10);
    chk("R5 regb", 8'(regb_q), 8'h00);
    chk("R5 wram", 8'(wram_off), 8'h0);
    chk("R5 unlock", 8'(prg_unlocked), 8'h0);
    chk("R5 pulses", 8'({tmr_pend_clr, tmr_cnt_clr}), 8'h0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_reset_state();

    // Table walk: R3, R4, R6, R7, R8, R9, R10
    prev_a = 5'h10;
    for (int i = 0; i < 8; i++) begin
      logic [22:0] v;
      v = VEC[i];
      ser(v[22:21], v[20:16]);
      if (v[22:21] == 2'd1) begin
        chk_a_pulses(prev_a, v[20:16]);
        prev_a = v[20:16];
      end
      chk("R4 ctrl", 8'(ctrl_q), 8'(v[15:11]));
      chk("R4 rega", 8'(rega_q), 8'(v[10:6]));
      chk("R4 regb", 8'(regb_q), 8'(v[5:1]));
      chk("R6 wram", 8'(wram_off), 8'(v[5]));
      chk("R7 unlock", 8'(prg_unlocked), 8'(v[0]));
    end

    // R2: restart mid-sequence, control bits 3:2 forced, no load
    wr(1'b1, 3'b100, 8'h01);
    wr(1'b1, 3'b100, 8'h01);
    wr(1'b1, 3'b100, 8'h80);
    chk("R2 ctrl forced", 8'(ctrl_q), 8'h0C);
    chk("R2 rega kept", 8'(rega_q), 8'h1C);
    ser(2'd3, 5'h11);
    chk("R2 shift cleared", 8'(regb_q), 8'h11);
    chk("R6 wram set", 8'(wram_off), 8'h1);

    // R1: writes with address bit 15 low or strobe low are ignored
    ser(2'd0, 5'h01);
    wr(1'b1, 3'b000, 8'h80);
    chk("R1 restart ignored", 8'(ctrl_q), 8'h01);
    wr(1'b1, 3'b011, 8'h01);
    wr(1'b0, 3'b111, 8'h01);
    chk("R1 regb kept", 8'(regb_q), 8'h11);
    ser(2'd3, 5'h02);
    chk("R1 count unaffected", 8'(regb_q), 8'h02);

    // R7: unlock stays high when bit 4 falls again
    ser(2'd1, 5'h00);
    chk_a_pulses(5'h1C, 5'h00);
    chk("R7 sticky", 8'(prg_unlocked), 8'h1);

    // R5: reset clears everything including unlock
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk_reset_state();

    // R7: storing 1 again without a prior low does not unlock
    ser(2'd1, 5'h10);
    chk_a_pulses(5'h10, 5'h10);
    chk("R7 no toggle", 8'(prg_unlocked), 8'h0);
    ser(2'd1, 5'h0F);
    chk_a_pulses(5'h10, 5'h0F);
    chk("R7 low only", 8'(prg_unlocked), 8'h0);
    ser(2'd1, 5'h1F);
    chk_a_pulses(5'h0F, 5'h1F);
    chk("R7 toggle unlocks", 8'(prg_unlocked), 8'h1);
    @(negedge clk);
    chk("R10 pulse one cycle", 8'({tmr_pend_clr, tmr_cnt_clr}), 8'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule